// File: doc/BRIEF.md
# Read/Write Port Start Arbiter

This block decides, on every rising clock edge, whether a read burst, a write burst or nothing begins in a memory with separate read and write ports. Each port has an active-low select and an address. A burst occupies its port for two cycles, so a port cannot start again on the edge right after it started. When both selects are active, the priority is not fixed and not round-robin. The port that did not start on the previous edge wins, and from a quiet state the read wins. If both selects stay active, starts therefore alternate read, write, read, write.

The outputs are registered. A granted request gives a one-cycle start strobe for its port, loads that port's address register on the granting edge, and updates a two-bit history code that records what started. Downstream burst engines use the strobes and the held addresses. Data movement and the storage array are outside this block.

Top module: `port_start_arbiter`

## Requirements
- R1: A synchronous active-high reset sets both start strobes to 0, the history code to 0 (idle) and both address registers to 0.
- R2: If the read select is low and the previous edge did not start a read, a read starts. rdStart is 1 in the cycle after the edge, and rdAddr holds the address sampled at that edge.
- R3: If the write select is low and the previous edge did not start a write, a write starts. This happens only when no read wins the same edge. wrStart is 1 in the cycle after the edge, and wrAddr holds the sampled address.
- R4: A read request on the edge right after a read start is ignored. No read starts and rdAddr keeps its value.
- R5: A write request on the edge right after a write start is ignored. No write starts and wrAddr keeps its value.
- R6: If both selects are low and nothing started on the previous edge, the read wins.
- R7: If both selects are low, the write wins after a read start and the read wins after a write start. Selects held low continuously from idle give the start sequence read, write, read, write.
- R8: At most one start happens per cycle. lastStart is 1 after a read start, 2 after a write start and 0 after an edge with no start.
- R9: A request that loses arbitration or is ignored leaves its address register unchanged.
- R10: If both selects are high, nothing starts and the history returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; requests are sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rdSelN | input | 1 | Read request, active low |
| wrSelN | input | 1 | Write request, active low |
| rdAddrIn | input | ADDR_W | Read address sampled with rdSelN |
| wrAddrIn | input | ADDR_W | Write address sampled with wrSelN |
| rdStart | output | 1 | One-cycle read start strobe |
| wrStart | output | 1 | One-cycle write start strobe |
| rdAddr | output | ADDR_W | Address of the last granted read |
| wrAddr | output | ADDR_W | Address of the last granted write |
| lastStart | output | 2 | History: 0 none, 1 read, 2 write |

## Verification
Every result of this block is due exactly one cycle after the edge that samples the request. The strobes, the address registers and lastStart all update on that same edge. The bench drives inputs just after an edge and samples the outputs 1 ns after the next rising edge, so each check looks at the decision made for the inputs it just drove. Expected addresses and grants come from a running model of the history in the bench. That model covers the ignored, losing and alternating cases.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    HIST_IDLE  = 2'd0,
    HIST_READ  = 2'd1,
    HIST_WRITE = 2'd2
  } hist_e;

  typedef struct packed {
    logic rdGo;
    logic wrGo;
  } ctrlStrobes_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         rdSelN,
  input  logic         wrSelN,
  output ctrlStrobes_t strobes,
  output hist_e        hist
);
  logic rdEligible;
  logic wrEligible;
  hist_e histNext;

  // A port may not start twice on consecutive edges
  assign rdEligible = !rdSelN && (hist != HIST_READ);
  assign wrEligible = !wrSelN && (hist != HIST_WRITE);

  // Both can be eligible only from idle, where the read takes priority
  always_comb begin
    strobes.rdGo = rdEligible;
    strobes.wrGo = wrEligible && !rdEligible;
    if (strobes.rdGo)      histNext = HIST_READ;
    else if (strobes.wrGo) histNext = HIST_WRITE;
    else                   histNext = HIST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) hist <= HIST_IDLE;
    else     hist <= histNext;
  end
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strobes,
  input  logic [ADDR_W-1:0]   rdAddrIn,
  input  logic [ADDR_W-1:0]   wrAddrIn,
  output logic                rdStart,
  output logic                wrStart,
  output logic [ADDR_W-1:0]   rdAddr,
  output logic [ADDR_W-1:0]   wrAddr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdStart <= 1'b0;
      wrStart <= 1'b0;
      rdAddr  <= '0;
      wrAddr  <= '0;
    end else begin
      rdStart <= strobes.rdGo;
      wrStart <= strobes.wrGo;
      if (strobes.rdGo) rdAddr <= rdAddrIn;
      if (strobes.wrGo) wrAddr <= wrAddrIn;
    end
  end
endmodule

// File: rtl/port_start_arbiter.sv
module port_start_arbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdSelN,
  input  logic              wrSelN,
  input  logic [ADDR_W-1:0] rdAddrIn,
  input  logic [ADDR_W-1:0] wrAddrIn,
  output logic              rdStart,
  output logic              wrStart,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [1:0]        lastStart
);
  ctrlStrobes_t strobes;
  hist_e        hist;

  arb_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .rdSelN  (rdSelN),
    .wrSelN  (wrSelN),
    .strobes (strobes),
    .hist    (hist)
  );

  arb_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .rdAddrIn (rdAddrIn),
    .wrAddrIn (wrAddrIn),
    .rdStart  (rdStart),
    .wrStart  (wrStart),
    .rdAddr   (rdAddr),
    .wrAddr   (wrAddr)
  );

  assign lastStart = hist;
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              rdSelN,
  input logic              wrSelN,
  input logic              rdStart,
  input logic              wrStart,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [1:0]        lastStart
);
  // R8
  one_start_chk: assert property (@(posedge clk) disable iff (rst)
    !(rdStart && wrStart));

  // R4
  no_rd_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    rdStart |=> !rdStart);

  // R5
  no_wr_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    wrStart |=> !wrStart);

  // R2
  rd_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdSelN && !rdStart) |=> rdStart);

  // R3
  wr_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (!wrSelN && !wrStart && (rdSelN || rdStart)) |=> wrStart);

  // R9
  rd_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rdStart |-> $stable(rdAddr));

  // R9
  wr_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrStart |-> $stable(wrAddr));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (rdSelN && wrSelN) |=> (!rdStart && !wrStart && lastStart == 2'd0));

  // R8
  hist_rd_chk: assert property (@(posedge clk) disable iff (rst)
    rdStart |-> lastStart == 2'd1);

  // R8
  hist_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wrStart |-> lastStart == 2'd2);
endmodule

bind port_start_arbiter arb_chk #(.ADDR_W(ADDR_W)) u_arb_chk (
  .clk       (clk),
  .rst       (rst),
  .rdSelN    (rdSelN),
  .wrSelN    (wrSelN),
  .rdStart   (rdStart),
  .wrStart   (wrStart),
  .rdAddr    (rdAddr),
  .wrAddr    (wrAddr),
  .lastStart (lastStart)
);

// File: tb/tb_port_start_arbiter.sv
`timescale 1ns/1ps
module tb_port_start_arbiter;
  localparam int ADDR_W = 20;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rdSelN = 1'b1;
  logic              wrSelN = 1'b1;
  logic [ADDR_W-1:0] rdAddrIn = '0;
  logic [ADDR_W-1:0] wrAddrIn = '0;
  logic              rdStart;
  logic              wrStart;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] wrAddr;
  logic [1:0]        lastStart;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int expRd = 0;
  int expWr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_start_arbiter #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .rdSelN(rdSelN), .wrSelN(wrSelN),
    .rdAddrIn(rdAddrIn), .wrAddrIn(wrAddrIn),
    .rdStart(rdStart), .wrStart(wrStart),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .lastStart(lastStart)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive requests, pass one rising edge, sample 1 ns later
  task automatic step(bit rd, bit wr, int ra, int wa);
    rdSelN = !rd;
    wrSelN = !wr;
    rdAddrIn = ADDR_W'(ra);
    wrAddrIn = ADDR_W'(wa);
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string req, bit rs, bit ws, int hist);
    chk({req, " rdStart"}, int'(rdStart), int'(rs));
    chk({req, " wrStart"}, int'(wrStart), int'(ws));
    chk({req, " lastStart"}, int'(lastStart), hist);
    chk({req, " rdAddr"}, int'(rdAddr), expRd);
    chk({req, " wrAddr"}, int'(wrAddr), expWr);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(1, 1, 'h5, 'h6);
    step(1, 1, 'h5, 'h6);
    expRd = 0; expWr = 0;
    expect_out("R1", 0, 0, 0);
    rst = 1'b0;
    step(0, 0, 0, 0);
  endtask

  task automatic t_single_read();
    step(1, 0, 'h12, 'h99);
    expRd = 'h12;
    expect_out("R2", 1, 0, 1);
    step(0, 0, 'h77, 'h88);
    expect_out("R10", 0, 0, 0);
  endtask

  task automatic t_single_write();
    step(0, 1, 'h66, 'h34);
    expWr = 'h34;
    expect_out("R3", 0, 1, 2);
    step(0, 0, 0, 0);
    expect_out("R10", 0, 0, 0);
  endtask

  task automatic t_rd_repeat();
    step(1, 0, 'h21, 0);
    expRd = 'h21;
    expect_out("R2", 1, 0, 1);
    step(1, 0, 'h22, 0);
    expect_out("R4", 0, 0, 0);
    step(1, 0, 'h23, 0);
    expRd = 'h23;
    expect_out("R2", 1, 0, 1);
    step(0, 0, 0, 0);
  endtask

  task automatic t_wr_repeat();
    step(0, 1, 0, 'h31);
    expWr = 'h31;
    expect_out("R3", 0, 1, 2);
    step(0, 1, 0, 'h32);
    expect_out("R5", 0, 0, 0);
    step(0, 1, 0, 'h33);
    expWr = 'h33;
    expect_out("R3", 0, 1, 2);
    step(0, 0, 0, 0);
  endtask

  task automatic t_both_alternate();
    step(1, 1, 'h40, 'h50);
    expRd = 'h40;
    expect_out("R6 R9", 1, 0, 1);
    for (int i = 1; i < 8; i++) begin
      step(1, 1, 'h40 + i, 'h50 + i);
      if (i % 2 == 1) begin
        expWr = 'h50 + i;
        expect_out("R7 R9", 0, 1, 2);
      end else begin
        expRd = 'h40 + i;
        expect_out("R7 R9", 1, 0, 1);
      end
    end
    step(0, 0, 0, 0);
    expect_out("R10", 0, 0, 0);
  endtask

  task automatic t_both_after_write();
    step(0, 1, 0, 'h60);
    expWr = 'h60;
    expect_out("R3", 0, 1, 2);
    step(1, 1, 'h70, 'h61);
    expRd = 'h70;
    expect_out("R7", 1, 0, 1);
    step(0, 0, 0, 0);
  endtask

  task automatic t_rd_then_wr_only();
    step(1, 0, 'h80, 0);
    expRd = 'h80;
    expect_out("R2", 1, 0, 1);
    step(1, 1, 'h81, 'h90);
    expWr = 'h90;
    expect_out("R7 R4", 0, 1, 2);
    step(0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_single_read();
    t_single_write();
    t_rd_repeat();
    t_wr_repeat();
    t_both_alternate();
    t_both_after_write();
    t_rd_then_wr_only();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule